// File: doc/BRIEF.md
# In-Order Retirement and Exception Entry Controller

This block sits at the back end of a small load/store pipeline. It holds the in-flight instructions in a circular queue in fetch order. Each slot carries four flags: execution finished, exception raised, data access started and data access completed. Every cycle the block decides which instruction retires. It also grants or withholds permission to start a data access, and it sequences the entry into the trap handler.

The rules keep every data access single. An instruction may not start its access until all older ones are complete. An instruction that has started an access is never thrown away silently. Interrupts wait for an open bus cycle to close. Before a handler is entered, older work retires and younger work is discarded. When discarded work had already completed an access, the restart cannot be exact. In that case a sticky status bit is raised, and any later attempt to resume traps.

Top module: `retire_ctrl`

## Requirements
- R1: The queue holds DEPTH (default 4) slots. `alloc_i` is accepted only while `alloc_ready_o` is high. It is high when the queue is not full, no queued instruction carries an exception and no interrupt is pending. `alloc_idx_o` gives the slot the next accepted instruction takes, and slot numbers advance by one modulo DEPTH.
- R2: At most one instruction retires per cycle. The oldest instruction retires (`commit_o` high, `commit_idx_o` = its slot) in the cycle after it is marked finished, provided it has no exception. A younger finished instruction waits behind an unfinished older one.
- R3: `mem_grant_o` is high for the requested slot only when all of these hold:
  - the slot is occupied and has not started an access;
  - the bus is idle;
  - every older slot is finished;
  - neither the slot nor any older slot carries an exception;
  - no interrupt is pending, unless an exception is also pending.
  A slot is therefore never granted twice.
- R4: While a granted access is open, no handler entry occurs. `mem_ack_i` marks the slot finished and access-completed, so the slot retires on the following cycle.
- R5: `mem_err_i` during an open access marks that access's own slot as excepting.
- R6: When the oldest slot carries an exception and the bus is idle, `enter_o` pulses for one cycle with `enter_irq_o` low. `restart_idx_o` names that slot, `abort_mask_o` has one bit set per occupied slot, and the queue is empty on the next cycle.
- R7: An interrupt (`irq_i`) is latched. It is taken when the bus is idle, no exception is queued and the oldest slot cannot retire. At that point `enter_o` pulses with `enter_irq_o` high, and `restart_idx_o` names the oldest slot, or the next free slot if the queue is empty. An interrupt that arrives during exception preparation is taken on the cycle after the exception entry.
- R8: `not_cont_o` is set at a handler entry if any discarded slot had completed a data access. It stays set until reset.
- R9: `resume_trap_o` equals `resume_i` while `not_cont_o` is set, and is low otherwise.
- R10: After reset the queue is empty, `alloc_ready_o` is high, `alloc_idx_o` is 0, no interrupt is pending and `not_cont_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_i | input | 1 | Fetch stage offers a new instruction |
| alloc_ready_o | output | 1 | New instruction may be accepted |
| alloc_idx_o | output | IW | Slot for the next accepted instruction |
| done_i | input | 1 | Execution finished for a slot |
| done_idx_i | input | IW | Slot that finished |
| exc_i | input | 1 | Synchronous exception reported for a slot |
| exc_idx_i | input | IW | Slot raising the exception |
| mem_req_i | input | 1 | A slot asks to start its data access |
| mem_req_idx_i | input | IW | Requesting slot |
| mem_grant_o | output | 1 | Data access may begin now |
| mem_ack_i | input | 1 | Open access completed successfully |
| mem_err_i | input | 1 | Open access failed |
| irq_i | input | 1 | External interrupt request |
| commit_o | output | 1 | Oldest instruction retires |
| commit_idx_o | output | IW | Slot of the oldest instruction |
| abort_mask_o | output | DEPTH | Slots discarded at handler entry |
| enter_o | output | 1 | Handler entry pulse |
| enter_irq_o | output | 1 | Entry is for an interrupt (low: exception) |
| restart_idx_o | output | IW | Slot of the instruction to restart |
| not_cont_o | output | 1 | Sticky: exact continuation impossible |
| resume_i | input | 1 | Software tries to resume |
| resume_trap_o | output | 1 | Resume refused, trap raised |

## Verification
Two events can land in the same cycle: an interrupt request and an exception preparation already under way. The bench first records an exception against a younger slot while the older slot is still unfinished, and then raises the interrupt. The exception entry must come first, after the older slot retires, with only younger slots discarded. The interrupt entry must follow on the very next cycle, on an empty queue. A second overlap is an access completion and a fault on the same slot in one cycle. This must discard a completed access and set the sticky status, and a behavioural reference model judges both cases on every clock.

// File: rtl/retire_pkg.sv
package retire_pkg;
  typedef struct packed {
    logic vld;  // slot occupied
    logic dn;   // execution finished
    logic ex;   // exception raised
    logic ms;   // data access started
    logic md;   // data access completed
  } slot_t;
endpackage

// File: rtl/retire_scan.sv
module retire_scan #(
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] vld_i,
  input  logic [DEPTH-1:0] dn_i,
  input  logic [DEPTH-1:0] ex_i,
  input  logic [IW-1:0]    head_i,
  output logic [DEPTH-1:0] older_done_o,
  output logic [DEPTH-1:0] clean_o,
  output logic             exc_any_o
);
  function automatic logic [IW-1:0] age_of(input logic [IW-1:0] idx, input logic [IW-1:0] hd);
    return idx - hd;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic od, cl;
    always_comb begin
      od = 1'b1;
      cl = 1'b1;
      for (int j = 0; j < DEPTH; j++) begin
        if (vld_i[j]) begin
          if ((age_of(IW'(j), head_i) < age_of(IW'(g), head_i)) && !dn_i[j]) od = 1'b0;
          if ((age_of(IW'(j), head_i) <= age_of(IW'(g), head_i)) && ex_i[j]) cl = 1'b0;
        end
      end
    end
    assign older_done_o[g] = od;
    assign clean_o[g]      = cl;
  end

  assign exc_any_o = |(vld_i & ex_i);
endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import retire_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_en,
  input  logic                  commit_en,
  input  logic                  flush_en,
  input  logic [DEPTH-1:0]      set_dn,
  input  logic [DEPTH-1:0]      set_ex,
  input  logic [DEPTH-1:0]      set_ms,
  input  logic [DEPTH-1:0]      set_md,
  output slot_t [DEPTH-1:0]     slots_o,
  output logic [IW-1:0]         head_o,
  output logic [IW-1:0]         tail_o,
  output logic [IW:0]           count_o
);
  slot_t [DEPTH-1:0] slots_q, slots_d;
  logic [IW-1:0]     head_q, head_d, tail_q, tail_d;
  logic [IW:0]       cnt_q, cnt_d;
  logic [DEPTH-1:0]  ms_now;
  logic              upd_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ms
    assign ms_now[g] = slots_q[g].vld & slots_q[g].ms;
  end

  assign upd_en = alloc_en | commit_en | flush_en | (|set_dn) | (|set_ex) | (|set_ms) | (|set_md);

  always_comb begin
    slots_d = slots_q;
    head_d  = head_q;
    tail_d  = tail_q;
    cnt_d   = cnt_q + (IW+1)'(alloc_en) - (IW+1)'(commit_en);
    for (int i = 0; i < DEPTH; i++) begin
      if (slots_q[i].vld) begin
        slots_d[i].dn = slots_q[i].dn | set_dn[i];
        slots_d[i].ex = slots_q[i].ex | set_ex[i];
        slots_d[i].ms = slots_q[i].ms | set_ms[i];
        slots_d[i].md = slots_q[i].md | set_md[i];
      end
    end
    if (commit_en) begin
      slots_d[head_q].vld = 1'b0;
      head_d = head_q + 1'b1;
    end
    if (alloc_en) begin
      slots_d[tail_q] = '{vld: 1'b1, default: 1'b0};
      tail_d = tail_q + 1'b1;
    end
    if (flush_en) begin
      for (int i = 0; i < DEPTH; i++) slots_d[i].vld = 1'b0;
      head_d = tail_q;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      slots_q <= slots_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
      cnt_q   <= cnt_d;
    end
  end

  assign slots_o = slots_q;
  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (cnt_q < (IW+1)'(DEPTH))); // R1
  AST_COMMIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> (slots_q[head_q].vld && slots_q[head_q].dn && !slots_q[head_q].ex)); // R2
  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ms & ms_now) == '0); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl
  import retire_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  output logic             alloc_ready_o,
  output logic [IW-1:0]    alloc_idx_o,
  input  logic             done_i,
  input  logic [IW-1:0]    done_idx_i,
  input  logic             exc_i,
  input  logic [IW-1:0]    exc_idx_i,
  input  logic             mem_req_i,
  input  logic [IW-1:0]    mem_req_idx_i,
  output logic             mem_grant_o,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  input  logic             irq_i,
  output logic             commit_o,
  output logic [IW-1:0]    commit_idx_o,
  output logic [DEPTH-1:0] abort_mask_o,
  output logic             enter_o,
  output logic             enter_irq_o,
  output logic [IW-1:0]    restart_idx_o,
  output logic             not_cont_o,
  input  logic             resume_i,
  output logic             resume_trap_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  slot_t [DEPTH-1:0] slots;
  logic [IW-1:0]     head, tail;
  logic [IW:0]       count;
  logic [DEPTH-1:0]  vld_v, dn_v, ex_v, md_v, older_done, clean;
  logic              exc_any;

  for (genvar g = 0; g < DEPTH; g++) begin : g_vec
    assign vld_v[g] = slots[g].vld;
    assign dn_v[g]  = slots[g].dn;
    assign ex_v[g]  = slots[g].ex;
    assign md_v[g]  = slots[g].md;
  end

  logic          busy_q, busy_d, irq_q, irq_d, nc_q, nc_d;
  logic [IW-1:0] bidx_q, bidx_d;
  logic          commit_w, enter_exc_w, enter_int_w, enter_w, irq_block, grant_w;
  logic          ack_w, err_w, alloc_en;
  logic [DEPTH-1:0] set_dn, set_ex, set_ms, set_md;

  retire_scan #(.DEPTH(DEPTH)) u_scan (
    .vld_i(vld_v), .dn_i(dn_v), .ex_i(ex_v), .head_i(head),
    .older_done_o(older_done), .clean_o(clean), .exc_any_o(exc_any)
  );

  retire_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_s),
    .alloc_en(alloc_en), .commit_en(commit_w), .flush_en(enter_w),
    .set_dn(set_dn), .set_ex(set_ex), .set_ms(set_ms), .set_md(set_md),
    .slots_o(slots), .head_o(head), .tail_o(tail), .count_o(count)
  );

  // retirement and handler-entry decisions
  always_comb begin
    commit_w    = slots[head].vld & slots[head].dn & ~slots[head].ex;
    enter_exc_w = slots[head].vld & slots[head].ex & ~busy_q;
    enter_int_w = irq_q & ~exc_any & ~busy_q & ~commit_w;
    enter_w     = enter_exc_w | enter_int_w;
    irq_block   = irq_q & ~exc_any;
    grant_w     = mem_req_i & slots[mem_req_idx_i].vld & ~slots[mem_req_idx_i].ms
                & ~busy_q & ~irq_block & ~enter_w
                & older_done[mem_req_idx_i] & clean[mem_req_idx_i];
    ack_w       = busy_q & mem_ack_i;
    err_w       = busy_q & mem_err_i & ~mem_ack_i;
    alloc_en    = alloc_i & alloc_ready_o;
  end

  always_comb begin
    set_dn = '0;
    set_ex = '0;
    set_ms = '0;
    set_md = '0;
    if (done_i)  set_dn[done_idx_i] = 1'b1;
    if (exc_i)   set_ex[exc_idx_i]  = 1'b1;
    if (ack_w) begin
      set_dn[bidx_q] = 1'b1;
      set_md[bidx_q] = 1'b1;
    end
    if (err_w)   set_ex[bidx_q] = 1'b1;
    if (grant_w) set_ms[mem_req_idx_i] = 1'b1;
  end

  always_comb begin
    busy_d = busy_q;
    bidx_d = bidx_q;
    if (grant_w) begin
      busy_d = 1'b1;
      bidx_d = mem_req_idx_i;
    end else if (ack_w || err_w) begin
      busy_d = 1'b0;
    end
    irq_d = irq_i | (irq_q & ~(enter_w & ~enter_exc_w));
    nc_d  = nc_q | (enter_w & |(vld_v & md_v));
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q <= 1'b0;
      bidx_q <= '0;
      irq_q  <= 1'b0;
      nc_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      bidx_q <= bidx_d;
      irq_q  <= irq_d;
      nc_q   <= nc_d;
    end
  end

  assign alloc_ready_o = (count < (IW+1)'(DEPTH)) & ~exc_any & ~irq_q;
  assign alloc_idx_o   = tail;
  assign mem_grant_o   = grant_w;
  assign commit_o      = commit_w;
  assign commit_idx_o  = head;
  assign abort_mask_o  = enter_w ? vld_v : '0;
  assign enter_o       = enter_w;
  assign enter_irq_o   = enter_int_w & ~enter_exc_w;
  assign restart_idx_o = head;
  assign not_cont_o    = nc_q;
  assign resume_trap_o = resume_i & nc_q;

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_q && !mem_ack_i && !mem_err_i) |=> busy_q); // R4
  AST_IRQ_KEPT: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_q && !enter_irq_o) |=> irq_q); // R7
  AST_NC_STICKY: assert property (@(posedge clk) disable iff (!rst_s)
    nc_q |=> nc_q); // R8
  AST_ENTER_DRAINS: assert property (@(posedge clk) disable iff (!rst_s)
    enter_o |=> !commit_o); // R6
endmodule

// File: tb/retire_ctrl_test.sv
`timescale 1ns/1ps
module retire_ctrl_test;
  localparam int D = 4;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_i = 0, done_i = 0, exc_i = 0, mem_req_i = 0, mem_ack_i = 0, mem_err_i = 0;
  logic irq_i = 0, resume_i = 0;
  logic [W-1:0] done_idx_i = 0, exc_idx_i = 0, mem_req_idx_i = 0;
  logic alloc_ready_o, mem_grant_o, commit_o, enter_o, enter_irq_o, not_cont_o, resume_trap_o;
  logic [W-1:0] alloc_idx_o, commit_idx_o, restart_idx_o;
  logic [D-1:0] abort_mask_o;

  retire_ctrl #(.DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .alloc_ready_o(alloc_ready_o),
    .alloc_idx_o(alloc_idx_o), .done_i(done_i), .done_idx_i(done_idx_i),
    .exc_i(exc_i), .exc_idx_i(exc_idx_i), .mem_req_i(mem_req_i),
    .mem_req_idx_i(mem_req_idx_i), .mem_grant_o(mem_grant_o), .mem_ack_i(mem_ack_i),
    .mem_err_i(mem_err_i), .irq_i(irq_i), .commit_o(commit_o), .commit_idx_o(commit_idx_o),
    .abort_mask_o(abort_mask_o), .enter_o(enter_o), .enter_irq_o(enter_irq_o),
    .restart_idx_o(restart_idx_o), .not_cont_o(not_cont_o), .resume_i(resume_i),
    .resume_trap_o(resume_trap_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // behavioural reference model
  bit mv[D], mdn[D], mex[D], mms[D], mmd[D];
  int mh = 0, mt = 0, mc = 0, mb = 0;
  bit mbusy = 0, mirq = 0, mnc = 0;

  // sampled outputs of the last tick
  logic s_ready, s_grant, s_commit, s_enter, s_eirq, s_nc, s_trap;
  logic [W-1:0] s_aidx, s_cidx, s_ridx;
  logic [D-1:0] s_abort;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int age(input int j);
    return (j - mh + D) % D;
  endfunction

  task automatic tick();
    bit ex_any, e_commit, e_eexc, e_eirq, e_enter, e_ready, e_grant, e_trap, e_ack, e_err;
    logic [D-1:0] e_abort;
    int r;
    @(negedge clk);
    ex_any = 0;
    for (int j = 0; j < D; j++) if (mv[j] && mex[j]) ex_any = 1;
    e_commit = mv[mh] && mdn[mh] && !mex[mh];
    e_eexc   = mv[mh] && mex[mh] && !mbusy;
    e_eirq   = mirq && !ex_any && !mbusy && !e_commit;
    e_enter  = e_eexc || e_eirq;
    e_ready  = (mc < D) && !ex_any && !mirq;
    r = int'(mem_req_idx_i);
    e_grant  = mem_req_i && mv[r] && !mms[r] && !mbusy && !(mirq && !ex_any) && !e_enter;
    for (int j = 0; j < D; j++) begin
      if (mv[j] && age(j) < age(r) && !mdn[j]) e_grant = 0;
      if (mv[j] && age(j) <= age(r) && mex[j]) e_grant = 0;
    end
    e_abort = '0;
    if (e_enter) for (int j = 0; j < D; j++) e_abort[j] = mv[j];
    e_trap = resume_i && mnc;

    s_ready = alloc_ready_o; s_grant = mem_grant_o; s_commit = commit_o; s_enter = enter_o;
    s_eirq = enter_irq_o; s_nc = not_cont_o; s_trap = resume_trap_o;
    s_aidx = alloc_idx_o; s_cidx = commit_idx_o; s_ridx = restart_idx_o; s_abort = abort_mask_o;

    chk("R1 alloc_ready", s_ready, e_ready);
    chk("R1 alloc_idx", s_aidx, mt);
    chk("R2 commit", s_commit, e_commit);
    chk("R2 commit_idx", s_cidx, mh);
    chk("R3 grant", s_grant, e_grant);
    chk("R3 single access", s_grant && mms[r], 0);
    chk("R6 enter", s_enter, e_enter);
    chk("R6 restart_idx", s_ridx, mh);
    chk("R6 abort_mask", s_abort, e_abort);
    if (e_enter) chk("R7 enter cause", s_eirq, !e_eexc);
    chk("R8 not_cont", s_nc, mnc);
    chk("R9 resume_trap", s_trap, e_trap);

    @(posedge clk);
    e_ack = mbusy && mem_ack_i;
    e_err = mbusy && mem_err_i && !mem_ack_i;
    if (e_enter) begin
      for (int j = 0; j < D; j++) begin
        if (mv[j] && mmd[j]) mnc = 1;
        mv[j] = 0;
      end
      mh = mt;
      mc = 0;
    end else begin
      if (done_i && mv[done_idx_i]) mdn[done_idx_i] = 1;
      if (exc_i && mv[exc_idx_i]) mex[exc_idx_i] = 1;
      if (e_ack) begin mdn[mb] = 1; mmd[mb] = 1; end
      if (e_err) mex[mb] = 1;
      if (e_grant) mms[r] = 1;
      if (e_commit) begin mv[mh] = 0; mh = (mh + 1) % D; mc--; end
      if (alloc_i && e_ready) begin
        mv[mt] = 1; mdn[mt] = 0; mex[mt] = 0; mms[mt] = 0; mmd[mt] = 0;
        mt = (mt + 1) % D; mc++;
      end
    end
    if (e_grant) begin mbusy = 1; mb = r; end
    else if (e_ack || e_err) mbusy = 0;
    mirq = irq_i || (mirq && !(e_enter && !e_eexc));
    #1;
    alloc_i = 0; done_i = 0; exc_i = 0; mem_req_i = 0; mem_ack_i = 0; mem_err_i = 0;
    irq_i = 0; resume_i = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int j = 0; j < D; j++) begin mv[j] = 0; mdn[j] = 0; mex[j] = 0; mms[j] = 0; mmd[j] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) tick();
    // R10 reset state
    chk("R10 ready after reset", s_ready, 1);
    chk("R10 alloc_idx after reset", s_aidx, 0);
    chk("R10 not_cont after reset", s_nc, 0);

    // R1 fill the queue
    for (int k = 0; k < D; k++) begin alloc_i = 1; tick(); end
    tick();
    chk("R1 full blocks alloc", s_ready, 0);

    // R2 out-of-order finish waits for the oldest
    done_i = 1; done_idx_i = 1; tick();
    tick();
    chk("R2 younger waits", s_commit, 0);
    done_i = 1; done_idx_i = 0; tick();
    tick();
    chk("R2 oldest retires", s_commit, 1);
    chk("R2 oldest idx", s_cidx, 0);
    tick();
    chk("R2 next idx", s_cidx, 1);

    // R3 / R4 access ordering
    mem_req_i = 1; mem_req_idx_i = 3; tick();
    chk("R3 older unfinished blocks", s_grant, 0);
    mem_req_i = 1; mem_req_idx_i = 2; tick();
    chk("R3 oldest granted", s_grant, 1);
    mem_req_i = 1; mem_req_idx_i = 3; tick();
    chk("R3 busy blocks", s_grant, 0);
    mem_ack_i = 1; tick();
    mem_req_i = 1; mem_req_idx_i = 2; tick();
    chk("R3 no second grant", s_grant, 0);
    chk("R4 ack marks finished", s_commit, 1);
    mem_req_i = 1; mem_req_idx_i = 3; tick();
    chk("R3 next granted", s_grant, 1);
    mem_ack_i = 1; tick();
    tick();
    chk("R4 commit after ack", s_cidx, 3);

    // R5 / R6 failed access
    for (int k = 0; k < 3; k++) begin alloc_i = 1; tick(); end
    mem_req_i = 1; mem_req_idx_i = 0; tick();
    mem_err_i = 1; tick();
    tick();
    chk("R5 failed access faults", s_enter, 1);
    chk("R6 exception cause", s_eirq, 0);
    chk("R6 restart slot", s_ridx, 0);
    chk("R6 aborted slots", s_abort, 4'b0111);
    tick();
    chk("R6 queue empty", s_ready, 1);

    // R4 / R7 interrupt deferred by open bus cycle
    for (int k = 0; k < 2; k++) begin alloc_i = 1; tick(); end
    mem_req_i = 1; mem_req_idx_i = 3; tick();
    irq_i = 1; tick();
    tick();
    chk("R4 no entry while bus open", s_enter, 0);
    mem_ack_i = 1; tick();
    tick();
    chk("R4 completed access retires", s_commit, 1);
    tick();
    chk("R7 interrupt entry", s_enter, 1);
    chk("R7 interrupt cause", s_eirq, 1);
    chk("R7 restart slot", s_ridx, 0);
    chk("R7 aborted slots", s_abort, 4'b0001);

    // R7 interrupt during exception preparation
    for (int k = 0; k < 3; k++) begin alloc_i = 1; tick(); end
    exc_i = 1; exc_idx_i = 2; tick();
    irq_i = 1; tick();
    tick();
    chk("R7 held during preparation", s_enter, 0);
    done_i = 1; done_idx_i = 1; tick();
    tick();
    chk("R6 older completes first", s_commit, 1);
    tick();
    chk("R6 exception first", s_enter, 1);
    chk("R6 exception cause kept", s_eirq, 0);
    chk("R6 younger aborted", s_abort, 4'b1100);
    tick();
    chk("R7 interrupt right after", s_enter, 1);
    chk("R7 interrupt cause after", s_eirq, 1);
    chk("R7 empty abort", s_abort, 4'b0000);

    // R8 / R9 completed access discarded
    resume_i = 1; tick();
    chk("R9 resume allowed", s_trap, 0);
    for (int k = 0; k < 2; k++) begin alloc_i = 1; tick(); end
    mem_req_i = 1; mem_req_idx_i = 0; tick();
    mem_ack_i = 1; exc_i = 1; exc_idx_i = 0; tick();
    tick();
    chk("R8 entry with completed access", s_enter, 1);
    tick();
    chk("R8 not_cont set", s_nc, 1);
    resume_i = 1; tick();
    chk("R9 resume traps", s_trap, 1);
    repeat (3) tick();
    chk("R8 not_cont sticky", s_nc, 1);

    finish_run();
  end
endmodule